// File: doc/BRIEF.md
# SPI Status Flag and Interrupt Request Controller

This block keeps the four status flags of an SPI peripheral and turns them into two CPU interrupt request lines. The shift engine reports events to it with single-cycle strobes: a finished byte, a byte that arrived while the receive buffer was still full, and a level that stays high while a mode fault condition exists. The CPU bus side gives it one strobe for each relevant register access: status read, receive data read, transmit data write and control write. Each flag is cleared by its own ordered access sequence and never directly.

One request line serves the transmitter. The other is shared by the receive full flag and by the two error flags. The block also makes the slave select gating decisions for the pin and shift logic that sit around it. While a slave is deselected, its serial data output is released and incoming serial clock edges are refused. A mode fault only raises a flag and never alters the enable input.

Top module: `spi_flag_irq_ctrl`

## Requirements
- R1: After reset the status vector reads 4'b1000 (transmit empty set, all others clear) and both request outputs are 0.
- R2: Status bit positions are fixed: bit 0 receive full, bit 1 overflow, bit 2 mode fault, bit 3 transmit empty. A byte-done strobe sets bits 0 and 3, an overrun strobe sets bit 1, and the mode fault level sets bit 2. Each change shows in the cycle after the strobe.
- R3: Transmit empty clears on a transmit data write alone, with no status read needed beforehand.
- R4: Receive full clears only when a status read that sees it set is followed by a receive data read. A receive data read without that status read leaves it set.
- R5: Overflow clears through the same status-read-then-data-read sequence as receive full.
- R6: Mode fault clears only when a status read that sees it set is followed by a control write, and only if the mode fault level is low at the status read, between the two steps and at the write. In every other case the flag stays set.
- R7: If any other register access falls between the two steps of a sequence, the sequence is cancelled and the flag stays set.
- R8: When a setting event arrives in the same cycle as the access that would clear a flag, the flag stays set.
- R9: The transmit request is 1 exactly when transmit empty, the transmit interrupt enable and the SPI enable are all 1.
- R10: The receive/error request equals (receive full AND receive enable) OR ((overflow OR mode fault) AND error enable), whatever the SPI enable.
- R11: With the SPI enabled in slave mode and slave select high, the data output enable and the serial clock accept output are both 0. With slave select low, both are 1. In master mode, the data output enable is 0 and clock accept is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_done_i | input | 1 | Shift engine finished a byte |
| rx_ovr_i | input | 1 | Byte received while receive buffer full |
| mode_flt_i | input | 1 | Mode fault condition present (level) |
| spi_en_i | input | 1 | SPI enable bit |
| master_i | input | 1 | 1 = master, 0 = slave |
| slv_sel_n_i | input | 1 | Slave select pin level |
| tx_ie_i | input | 1 | Transmit interrupt enable |
| rx_ie_i | input | 1 | Receive interrupt enable |
| err_ie_i | input | 1 | Error interrupt enable |
| stat_rd_i | input | 1 | Status register read strobe |
| data_rd_i | input | 1 | Receive data register read strobe |
| data_wr_i | input | 1 | Transmit data register write strobe |
| ctrl_wr_i | input | 1 | Control register write strobe |
| status_o | output | 4 | Flag vector (bit map in R2) |
| tx_irq_o | output | 1 | Transmitter interrupt request |
| rxerr_irq_o | output | 1 | Receiver/error interrupt request |
| miso_oe_o | output | 1 | Serial data output drive enable |
| sck_ok_o | output | 1 | Serial clock edges accepted |

## Verification
The embedded assertions check on every cycle that a setting event always leaves its flag set, that no flag falls without the second-step access, and that mode fault never falls after a cycle in which the condition was present. They also check that neither request rises while its gating enables are off and that a deselected slave neither drives data nor accepts clock edges. Only the directed scenarios can show that a full two-step sequence actually clears a flag. The same holds for the interleaved access that cancels an armed sequence, the mode fault arriving mid-sequence, and the request lines rising exactly when their terms are all true.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

   localparam int unsigned NFLAG  = 4;
   localparam int unsigned FL_RXF = 0;
   localparam int unsigned FL_OVR = 1;
   localparam int unsigned FL_MOD = 2;
   localparam int unsigned FL_TXE = 3;

   typedef enum logic [1:0] {
      CLR_ONE_WRITE = 2'd0,
      CLR_STAT_READ = 2'd1,
      CLR_STAT_CTRL = 2'd2
   } clr_kind_e;

   function automatic clr_kind_e kind_of(input int unsigned idx);
      case (idx)
         FL_TXE:  kind_of = CLR_ONE_WRITE;
         FL_MOD:  kind_of = CLR_STAT_CTRL;
         default: kind_of = CLR_STAT_READ;
      endcase
   endfunction

endpackage

// File: rtl/spi_flag_cell.sv
module spi_flag_cell
   import spi_flag_pkg::*;
#(
   parameter clr_kind_e KIND    = CLR_STAT_READ,
   parameter bit        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic access_i,
   input  logic arm_rd_i,
   input  logic step2_i,
   input  logic block_i,
   output logic flag_o
);

   logic flag_q;
   logic clr;

   generate
      if (KIND == CLR_ONE_WRITE) begin : g_one
         assign clr = step2_i;
      end else begin : g_two
         logic armed_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               armed_q <= 1'b0;
            else if (block_i)
               armed_q <= 1'b0;
            else if (access_i)
               armed_q <= arm_rd_i & flag_q;
         end
         assign clr = armed_q & step2_i & ~block_i;

         // R4
         fell_needs_step2_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_q) |-> $past(step2_i));

         // R6
         no_clear_under_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(flag_q) |-> !$past(block_i));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_q <= RST_VAL;
      else
         flag_q <= set_i | (flag_q & ~clr);
   end

   assign flag_o = flag_q;

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_q);

endmodule

// File: rtl/spi_irq_merge.sv
module spi_irq_merge
   import spi_flag_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] flags_i,
   input  logic             spi_en_i,
   input  logic             tx_ie_i,
   input  logic             rx_ie_i,
   input  logic             err_ie_i,
   output logic             tx_irq_o,
   output logic             rxerr_irq_o
);

   logic tx_raw;
   logic rxerr_raw;

   always_comb begin
      tx_raw    = flags_i[FL_TXE] & tx_ie_i & spi_en_i;
      rxerr_raw = (flags_i[FL_RXF] & rx_ie_i)
                | ((flags_i[FL_OVR] | flags_i[FL_MOD]) & err_ie_i);
   end

   generate
      if (IRQ_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tx_irq_o    <= 1'b0;
               rxerr_irq_o <= 1'b0;
            end else begin
               tx_irq_o    <= tx_raw;
               rxerr_irq_o <= rxerr_raw;
            end
         end
      end else begin : g_comb
         assign tx_irq_o    = tx_raw;
         assign rxerr_irq_o = rxerr_raw;

         // R9
         tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tx_irq_o |-> (spi_en_i && tx_ie_i));

         // R10
         rxerr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!rx_ie_i && !err_ie_i) |-> !rxerr_irq_o);
      end
   endgenerate

endmodule

// File: rtl/spi_ss_gate.sv
module spi_ss_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_en_i,
   input  logic master_i,
   input  logic slv_sel_n_i,
   output logic miso_oe_o,
   output logic sck_ok_o
);

   always_comb begin
      miso_oe_o = spi_en_i & ~master_i & ~slv_sel_n_i;
      sck_ok_o  = spi_en_i & (master_i | ~slv_sel_n_i);
   end

   // R11
   deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!master_i && slv_sel_n_i) |-> (!miso_oe_o && !sck_ok_o));

endmodule

// File: rtl/spi_flag_irq_ctrl.sv
module spi_flag_irq_ctrl
   import spi_flag_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_done_i,
   input  logic             rx_ovr_i,
   input  logic             mode_flt_i,
   input  logic             spi_en_i,
   input  logic             master_i,
   input  logic             slv_sel_n_i,
   input  logic             tx_ie_i,
   input  logic             rx_ie_i,
   input  logic             err_ie_i,
   input  logic             stat_rd_i,
   input  logic             data_rd_i,
   input  logic             data_wr_i,
   input  logic             ctrl_wr_i,
   output logic [NFLAG-1:0] status_o,
   output logic             tx_irq_o,
   output logic             rxerr_irq_o,
   output logic             miso_oe_o,
   output logic             sck_ok_o
);

   initial begin : p_param_chk
      if (NFLAG != 4) $fatal(1, "spi_flag_irq_ctrl: flag count must be 4");
   end

   logic             access;
   logic [NFLAG-1:0] set_v;
   logic [NFLAG-1:0] step2_v;
   logic [NFLAG-1:0] block_v;
   logic [NFLAG-1:0] flags;

   always_comb begin
      access          = stat_rd_i | data_rd_i | data_wr_i | ctrl_wr_i;
      set_v           = '0;
      step2_v         = '0;
      block_v         = '0;
      set_v[FL_RXF]   = byte_done_i;
      set_v[FL_TXE]   = byte_done_i;
      set_v[FL_OVR]   = rx_ovr_i;
      set_v[FL_MOD]   = mode_flt_i;
      step2_v[FL_RXF] = data_rd_i;
      step2_v[FL_OVR] = data_rd_i;
      step2_v[FL_MOD] = ctrl_wr_i;
      step2_v[FL_TXE] = data_wr_i;
      block_v[FL_MOD] = mode_flt_i;
   end

   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_flag
         spi_flag_cell #(
            .KIND    (kind_of(i)),
            .RST_VAL (i == FL_TXE)
         ) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (set_v[i]),
            .access_i (access),
            .arm_rd_i (stat_rd_i),
            .step2_i  (step2_v[i]),
            .block_i  (block_v[i]),
            .flag_o   (flags[i])
         );
      end
   endgenerate

   assign status_o = flags;

   spi_irq_merge #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk         (clk),
      .rst_n       (rst_n),
      .flags_i     (flags),
      .spi_en_i    (spi_en_i),
      .tx_ie_i     (tx_ie_i),
      .rx_ie_i     (rx_ie_i),
      .err_ie_i    (err_ie_i),
      .tx_irq_o    (tx_irq_o),
      .rxerr_irq_o (rxerr_irq_o)
   );

   spi_ss_gate u_ss (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_en_i    (spi_en_i),
      .master_i    (master_i),
      .slv_sel_n_i (slv_sel_n_i),
      .miso_oe_o   (miso_oe_o),
      .sck_ok_o    (sck_ok_o)
   );

   // R2
   ovr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovr_i |=> status_o[FL_OVR]);

   // R3
   txe_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr_i && !byte_done_i) |=> !status_o[FL_TXE]);

endmodule

// File: tb/sim_spi_flag_irq_ctrl.sv
module sim_spi_flag_irq_ctrl;

   localparam time CLK_PERIOD = 10ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic byte_done_i = 0, rx_ovr_i = 0, mode_flt_i = 0;
   logic spi_en_i = 0, master_i = 0, slv_sel_n_i = 1;
   logic tx_ie_i = 0, rx_ie_i = 0, err_ie_i = 0;
   logic stat_rd_i = 0, data_rd_i = 0, data_wr_i = 0, ctrl_wr_i = 0;
   logic [3:0] status_o;
   logic tx_irq_o, rxerr_irq_o, miso_oe_o, sck_ok_o;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_flag_irq_ctrl u0 (.*);

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   // one clock edge, then drop every access/event strobe
   task automatic step();
      @(posedge clk);
      @(negedge clk);
      byte_done_i = 0; rx_ovr_i = 0;
      stat_rd_i = 0; data_rd_i = 0; data_wr_i = 0; ctrl_wr_i = 0;
   endtask

   task automatic t_reset();
      check("R1 status", status_o, 4'b1000);
      check("R1 irqs", {2'b00, tx_irq_o, rxerr_irq_o}, 4'b0000);
   endtask

   task automatic t_txe();
      data_wr_i = 1; step();
      check("R3 txe cleared by write", status_o, 4'b0000);
      byte_done_i = 1; step();
      check("R2 byte done sets rxf and txe", status_o, 4'b1001);
   endtask

   task automatic t_rxf();
      data_rd_i = 1; step();
      check("R4 data read alone keeps rxf", status_o, 4'b1001);
      stat_rd_i = 1; step();
      data_rd_i = 1; step();
      check("R4 rxf cleared by sequence", status_o, 4'b1000);
   endtask

   task automatic t_ovr();
      rx_ovr_i = 1; step();
      check("R2 overrun sets ovr", status_o, 4'b1010);
      stat_rd_i = 1; step();
      data_rd_i = 1; step();
      check("R5 ovr cleared by sequence", status_o, 4'b1000);
   endtask

   task automatic t_mod();
      mode_flt_i = 1; step(); mode_flt_i = 0;
      check("R2 mode fault sets mod", status_o, 4'b1100);
      stat_rd_i = 1; step();
      ctrl_wr_i = 1; step();
      check("R6 mod cleared by sequence", status_o, 4'b1000);
      mode_flt_i = 1; step(); mode_flt_i = 0;
      stat_rd_i = 1; step();
      mode_flt_i = 1; step(); mode_flt_i = 0;
      ctrl_wr_i = 1; step();
      check("R6 fault between steps keeps mod", status_o, 4'b1100);
      stat_rd_i = 1; step();
      mode_flt_i = 1; ctrl_wr_i = 1; step(); mode_flt_i = 0;
      check("R6 fault at write keeps mod", status_o, 4'b1100);
      mode_flt_i = 1; stat_rd_i = 1; step(); mode_flt_i = 0;
      ctrl_wr_i = 1; step();
      check("R6 fault at status read keeps mod", status_o, 4'b1100);
      stat_rd_i = 1; step();
      ctrl_wr_i = 1; step();
      check("R6 clean sequence clears mod", status_o, 4'b1000);
   endtask

   task automatic t_cancel();
      rx_ovr_i = 1; step();
      stat_rd_i = 1; step();
      ctrl_wr_i = 1; step();
      data_rd_i = 1; step();
      check("R7 interleaved write cancels", status_o, 4'b1010);
      stat_rd_i = 1; step();
      data_wr_i = 1; step();
      data_rd_i = 1; step();
      check("R7 interleaved data write cancels", status_o, 4'b0010);
      stat_rd_i = 1; step();
      data_rd_i = 1; step();
      check("R5 ovr cleared after cancel", status_o, 4'b0000);
   endtask

   task automatic t_collide();
      byte_done_i = 1; step();
      stat_rd_i = 1; step();
      data_rd_i = 1; byte_done_i = 1; step();
      check("R8 byte done beats rxf clear", status_o, 4'b1001);
      data_wr_i = 1; byte_done_i = 1; step();
      check("R8 byte done beats txe clear", status_o, 4'b1001);
      stat_rd_i = 1; step();
      data_rd_i = 1; step();
      check("R4 rxf cleared again", status_o, 4'b1000);
   endtask

   task automatic t_irq();
      tx_ie_i = 1; spi_en_i = 0; #1;
      check("R9 no tx irq while disabled", {3'b000, tx_irq_o}, 4'b0000);
      spi_en_i = 1; #1;
      check("R9 tx irq when all set", {3'b000, tx_irq_o}, 4'b0001);
      tx_ie_i = 0; #1;
      check("R9 tx irq needs enable", {3'b000, tx_irq_o}, 4'b0000);
      tx_ie_i = 1; spi_en_i = 0; rx_ie_i = 1;
      byte_done_i = 1; step();
      check("R10 rx irq with spi disabled", {3'b000, rxerr_irq_o}, 4'b0001);
      rx_ie_i = 0; #1;
      check("R10 rx irq needs enable", {3'b000, rxerr_irq_o}, 4'b0000);
      rx_ovr_i = 1; step();
      check("R10 ovr gated off", {3'b000, rxerr_irq_o}, 4'b0000);
      err_ie_i = 1; #1;
      check("R10 ovr request", {3'b000, rxerr_irq_o}, 4'b0001);
      stat_rd_i = 1; step();
      data_rd_i = 1; step();
      mode_flt_i = 1; step(); mode_flt_i = 0;
      check("R10 mod request", {3'b000, rxerr_irq_o}, 4'b0001);
      err_ie_i = 0; tx_ie_i = 0; #1;
      check("R10 mod gated off", {3'b000, rxerr_irq_o}, 4'b0000);
   endtask

   task automatic t_ss();
      spi_en_i = 1; master_i = 0; slv_sel_n_i = 1; #1;
      check("R11 deselected slave", {2'b00, miso_oe_o, sck_ok_o}, 4'b0000);
      slv_sel_n_i = 0; #1;
      check("R11 selected slave", {2'b00, miso_oe_o, sck_ok_o}, 4'b0011);
      master_i = 1; slv_sel_n_i = 1; #1;
      check("R11 master", {2'b00, miso_oe_o, sck_ok_o}, 4'b0001);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_txe();
      t_rxf();
      t_ovr();
      t_mod();
      t_cancel();
      t_collide();
      t_irq();
      t_ss();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule